// File: doc/BRIEF.md
# Serial Port Register Front-End with Byte Queues

This block is the host-facing side of a classic asynchronous serial port. A host reaches eight byte-wide locations over a small bus with a 3-bit address, a write strobe and a read strobe. Bytes written for transmission go into a 16-entry queue. The transmit shifter drains that queue through a valid/ready handshake. Bytes from the receive shifter land in a second 16-entry queue, which the host drains by reading. The block holds the framing and baud-divisor settings and drives them to the shifters, which are outside this block.

Some locations have two meanings. The data location is the receive queue on read and the transmit queue on write. A bank-select bit in the framing register maps the data location and the enable location onto the two divisor bytes instead. A status location reports queue state and receive faults. An identification location reports the most urgent pending interrupt cause, and writes to that same location clear either queue. Modem control is plain storage, and modem status is a pass-through of an input.

Top module: `serRegFile`

## Requirements
- R1: After reset, framing reads 0x03, interrupt enable reads 0x00, divisor is 1, line status reads 0x60 when `txIdle` is high, identification reads 0xC1, `irqOut` is low and `txValid` is low.
- R2: With the bank bit (framing bit 7) clear, a write to offset 0 appends the byte to the transmit queue. `txValid`/`txData` show the oldest entry, and an entry is removed on each clock edge where `txValid` and `txReady` are both high.
- R3: With the bank bit clear, a read of offset 0 returns the oldest received byte and removes it. Line status bit 0 is high exactly while the receive queue holds a byte.
- R4: With the bank bit set, offsets 0 and 1 read and write the divisor low and high bytes, and `divisor` = {high, low}. Such writes leave the transmit queue and the interrupt enable untouched.
- R5: The framing register at offset 3 is readable and drives `wordLen`=bits 1:0 (5 to 8 data bits), `stopSel`=bit 2, `parEn`=bit 3, `parEven`=bit 4, `parStick`=bit 5 and `brkCtrl`=bit 6.
- R6: Each queue holds 16 bytes. A host write to a full transmit queue is discarded. Line status bit 5 is high while the transmit queue is empty.
- R7: A byte that arrives while the receive queue is full is dropped and sets the overrun flag (line status bit 1). A read of line status (offset 5) clears that flag.
- R8: Received parity, framing and break faults set sticky line status bits 2, 3 and 4. A read of line status returns them and then clears them.
- R9: A write to offset 2 with bit 1 set empties the receive queue, and a write with bit 2 set empties the transmit queue. Each clear is independent of the other.
- R10: Offset 2 reads 0xC6 for a line fault, 0xC4 for received data and 0xC2 for an empty transmit queue, taking the first of these that applies. It reads 0xC1 when none applies. Only causes enabled by interrupt enable bits 2, 0 and 1 respectively count. `irqOut` is high exactly when a cause applies, and reading offset 2 has no side effect.
- R11: Line status bit 6 is high only when the transmit queue is empty and `txIdle` is high.
- R12: Offset 4 stores modem control bits 4:0, reads them back and drives them on `mcrOut`. Offset 6 reads `msrIn`, and offset 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe; read side effects occur on the clock edge |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte for the current offset |
| irqOut | output | 1 | Interrupt request |
| txData | output | 8 | Oldest transmit entry |
| txValid | output | 1 | Transmit queue not empty |
| txReady | input | 1 | Shifter takes the entry |
| txIdle | input | 1 | Transmit shifter has nothing in flight |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | Received byte strobe |
| rxParErr | input | 1 | Parity fault with this byte |
| rxFrmErr | input | 1 | Framing fault with this byte |
| rxBrk | input | 1 | Break seen with this byte |
| divisor | output | 16 | Baud divisor |
| wordLen | output | 2 | Data bits minus 5 |
| stopSel | output | 1 | Extra stop bit |
| parEn | output | 1 | Parity enable |
| parEven | output | 1 | Even parity select |
| parStick | output | 1 | Fixed parity select |
| brkCtrl | output | 1 | Force line low |
| mcrOut | output | 5 | Modem control bits |
| msrIn | input | 8 | Modem status bits |

## Verification
A table of framing values with mixed bit patterns is walked to show that each field goes to its own output and reads back unchanged. Directed sequences then cover several cases. The queues are filled past 16 entries to tell drop-on-full apart from overwrite, and drained to confirm oldest-first order. The bank bit is toggled to show that divisor writes never leak into the transmit queue or the enable register. Faults are injected one at a time, and the enable mask is stepped, so that the identification code distinguishes fault, data and empty causes by priority and shows the read-to-clear behaviour.

// File: rtl/serRegPkg.sv
package serRegPkg;
  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_IER  = 3'd1;
  localparam logic [2:0] ADDR_IIR  = 3'd2;
  localparam logic [2:0] ADDR_LCR  = 3'd3;
  localparam logic [2:0] ADDR_MCR  = 3'd4;
  localparam logic [2:0] ADDR_LSR  = 3'd5;
  localparam logic [2:0] ADDR_MSR  = 3'd6;

  localparam logic [7:0] IIR_LINE = 8'hC6;
  localparam logic [7:0] IIR_RXD  = 8'hC4;
  localparam logic [7:0] IIR_TXE  = 8'hC2;
  localparam logic [7:0] IIR_NONE = 8'hC1;

  typedef struct packed {
    logic       txPush;
    logic       rxPop;
    logic       txClr;
    logic       rxClr;
    logic       errClr;
    logic [7:0] wrByte;
  } strobeT;

  typedef struct packed {
    logic       rxEmpty;
    logic       txEmpty;
    logic       overrun;
    logic       parErr;
    logic       frmErr;
    logic       brkErr;
    logic [7:0] rxHead;
  } statusT;
endpackage

// File: rtl/serFifo.sv
module serFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == FULL_CNT);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    push && full && !pop && !clr |=> full && (count == FULL_CNT)); // R6
  AST_EMPTY_NO_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    pop && empty && !push && !clr |=> empty); // R3
endmodule

// File: rtl/serRegData.sv
module serRegData
  import serRegPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     strobe,
  input  logic       txReady,
  input  logic [7:0] rxByte,
  input  logic       rxValid,
  input  logic       rxParErr,
  input  logic       rxFrmErr,
  input  logic       rxBrk,
  output statusT     status,
  output logic [7:0] txData,
  output logic       txValid
);
  logic txEmpty, txFull, rxEmpty, rxFull;
  logic [7:0] rxHead;
  logic overrunQ, parQ, frmQ, brkQ;

  serFifo #(.WIDTH(8), .DEPTH(DEPTH)) txQueue (
    .clk(clk), .rstN(rstN), .push(strobe.txPush), .pop(txReady),
    .clr(strobe.txClr), .din(strobe.wrByte), .head(txData),
    .empty(txEmpty), .full(txFull)
  );

  serFifo #(.WIDTH(8), .DEPTH(DEPTH)) rxQueue (
    .clk(clk), .rstN(rstN), .push(rxValid), .pop(strobe.rxPop),
    .clr(strobe.rxClr), .din(rxByte), .head(rxHead),
    .empty(rxEmpty), .full(rxFull)
  );

  assign txValid = !txEmpty;

  // fault flags: a new fault in the same cycle as a clearing read wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrunQ <= 1'b0;
      parQ     <= 1'b0;
      frmQ     <= 1'b0;
      brkQ     <= 1'b0;
    end else begin
      overrunQ <= (rxValid && rxFull)   || (overrunQ && !strobe.errClr);
      parQ     <= (rxValid && rxParErr) || (parQ && !strobe.errClr);
      frmQ     <= (rxValid && rxFrmErr) || (frmQ && !strobe.errClr);
      brkQ     <= (rxValid && rxBrk)    || (brkQ && !strobe.errClr);
    end
  end

  always_comb begin
    status.rxEmpty = rxEmpty;
    status.txEmpty = txEmpty;
    status.overrun = overrunQ;
    status.parErr  = parQ;
    status.frmErr  = frmQ;
    status.brkErr  = brkQ;
    status.rxHead  = rxHead;
  end

  AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxFull |=> status.overrun); // R7
  AST_ERR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errClr && !rxValid |=> !status.overrun && !status.parErr && !status.frmErr && !status.brkErr); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady && !strobe.txClr |=> txValid && $stable(txData)); // R2
  AST_TX_FULL_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    txFull && strobe.txPush && !txReady && !strobe.txClr |=> txValid && $stable(txData)); // R6
endmodule

// File: rtl/serRegCtrl.sv
module serRegCtrl
  import serRegPkg::*;
#(
  parameter logic [15:0] DIV_INIT = 16'd1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busWrData,
  input  statusT      status,
  input  logic        txIdle,
  input  logic [7:0]  msrIn,
  output strobeT      strobe,
  output logic [7:0]  busRdData,
  output logic        irqOut,
  output logic [15:0] divisor,
  output logic [7:0]  lcrOut,
  output logic [4:0]  mcrOut
);
  logic [7:0] lcrQ, dllQ, dlmQ;
  logic [2:0] ierQ;
  logic [4:0] mcrQ;
  logic bankSel;
  logic lineSrc, rxSrc, txSrc;
  logic [7:0] iirVal, lsrVal;

  assign bankSel = lcrQ[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcrQ <= 8'h03;
      ierQ <= '0;
      mcrQ <= '0;
      dllQ <= DIV_INIT[7:0];
      dlmQ <= DIV_INIT[15:8];
    end else if (busWrEn) begin
      case (busAddr)
        ADDR_DATA: if (bankSel) dllQ <= busWrData;
        ADDR_IER:  if (bankSel) dlmQ <= busWrData; else ierQ <= busWrData[2:0];
        ADDR_LCR:  lcrQ <= busWrData;
        ADDR_MCR:  mcrQ <= busWrData[4:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    strobe.txPush = busWrEn && (busAddr == ADDR_DATA) && !bankSel;
    strobe.rxPop  = busRdEn && (busAddr == ADDR_DATA) && !bankSel;
    strobe.txClr  = busWrEn && (busAddr == ADDR_IIR) && busWrData[2];
    strobe.rxClr  = busWrEn && (busAddr == ADDR_IIR) && busWrData[1];
    strobe.errClr = busRdEn && (busAddr == ADDR_LSR);
    strobe.wrByte = busWrData;
  end

  assign lineSrc = ierQ[2] && (status.overrun || status.parErr || status.frmErr || status.brkErr);
  assign rxSrc   = ierQ[0] && !status.rxEmpty;
  assign txSrc   = ierQ[1] && status.txEmpty;
  assign irqOut  = lineSrc || rxSrc || txSrc;

  always_comb begin
    if (lineSrc)    iirVal = IIR_LINE;
    else if (rxSrc) iirVal = IIR_RXD;
    else if (txSrc) iirVal = IIR_TXE;
    else            iirVal = IIR_NONE;
  end

  assign lsrVal = {1'b0, status.txEmpty && txIdle, status.txEmpty, status.brkErr,
                   status.frmErr, status.parErr, status.overrun, !status.rxEmpty};

  always_comb begin
    case (busAddr)
      ADDR_DATA: busRdData = bankSel ? dllQ : status.rxHead;
      ADDR_IER:  busRdData = bankSel ? dlmQ : {5'b0, ierQ};
      ADDR_IIR:  busRdData = iirVal;
      ADDR_LCR:  busRdData = lcrQ;
      ADDR_MCR:  busRdData = {3'b0, mcrQ};
      ADDR_LSR:  busRdData = lsrVal;
      ADDR_MSR:  busRdData = msrIn;
      default:   busRdData = 8'h00;
    endcase
  end

  assign divisor = {dlmQ, dllQ};
  assign lcrOut  = lcrQ;
  assign mcrOut  = mcrQ;

  AST_DIV_LOW_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr == ADDR_DATA) && bankSel |=> divisor[7:0] == $past(busWrData)); // R4
  AST_IER_BANKED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr == ADDR_IER) && bankSel |=> $stable(ierQ)); // R4
  AST_NO_CAUSE_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (ierQ == 3'b000) |-> !irqOut && (busAddr != ADDR_IIR || busRdData == IIR_NONE)); // R10
endmodule

// File: rtl/serRegFile.sv
module serRegFile
  import serRegPkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter logic [15:0] DIV_INIT = 16'd1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  output logic        irqOut,
  output logic [7:0]  txData,
  output logic        txValid,
  input  logic        txReady,
  input  logic        txIdle,
  input  logic [7:0]  rxByte,
  input  logic        rxValid,
  input  logic        rxParErr,
  input  logic        rxFrmErr,
  input  logic        rxBrk,
  output logic [15:0] divisor,
  output logic [1:0]  wordLen,
  output logic        stopSel,
  output logic        parEn,
  output logic        parEven,
  output logic        parStick,
  output logic        brkCtrl,
  output logic [4:0]  mcrOut,
  input  logic [7:0]  msrIn
);
  strobeT strobe;
  statusT status;
  logic [7:0] lcrOut;

  serRegCtrl #(.DIV_INIT(DIV_INIT)) ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .status(status),
    .txIdle(txIdle), .msrIn(msrIn), .strobe(strobe), .busRdData(busRdData),
    .irqOut(irqOut), .divisor(divisor), .lcrOut(lcrOut), .mcrOut(mcrOut)
  );

  serRegData #(.DEPTH(DEPTH)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txReady(txReady),
    .rxByte(rxByte), .rxValid(rxValid), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxBrk(rxBrk), .status(status),
    .txData(txData), .txValid(txValid)
  );

  assign wordLen  = lcrOut[1:0];
  assign stopSel  = lcrOut[2];
  assign parEn    = lcrOut[3];
  assign parEven  = lcrOut[4];
  assign parStick = lcrOut[5];
  assign brkCtrl  = lcrOut[6];
endmodule

// File: tb/serRegFile_test.sv
module serRegFile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {framing byte, expected {wordLen, stopSel, parEn, parEven, parStick, brkCtrl}}
  localparam logic [14:0] LCR_VEC [NVEC] = '{
    {8'h00, 7'b00_0_0_0_0_0},
    {8'h1B, 7'b11_0_1_1_0_0},
    {8'h2E, 7'b10_1_1_0_1_0},
    {8'h45, 7'b01_1_0_0_0_1},
    {8'h3F, 7'b11_1_1_1_1_0},
    {8'h03, 7'b11_0_0_0_0_0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0, busRdData;
  logic irqOut, txValid, txReady = 1'b0, txIdle = 1'b1;
  logic [7:0] txData, rxByte = '0, msrIn = '0;
  logic rxValid = 1'b0, rxParErr = 1'b0, rxFrmErr = 1'b0, rxBrk = 1'b0;
  logic [15:0] divisor;
  logic [1:0] wordLen;
  logic stopSel, parEn, parEven, parStick, brkCtrl;
  logic [4:0] mcrOut;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serRegFile uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .txData(txData), .txValid(txValid), .txReady(txReady),
    .txIdle(txIdle), .rxByte(rxByte), .rxValid(rxValid), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxBrk(rxBrk), .divisor(divisor), .wordLen(wordLen),
    .stopSel(stopSel), .parEn(parEn), .parEven(parEven), .parStick(parStick),
    .brkCtrl(brkCtrl), .mcrOut(mcrOut), .msrIn(msrIn)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    busRead(a, d);
    check(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic rxPush(input logic [7:0] d, input logic pe, input logic fe, input logic bi);
    @(negedge clk);
    rxByte = d; rxParErr = pe; rxFrmErr = fe; rxBrk = bi; rxValid = 1'b1;
    @(posedge clk); #1;
    rxValid = 1'b0; rxParErr = 1'b0; rxFrmErr = 1'b0; rxBrk = 1'b0;
  endtask

  task automatic txTake();
    @(negedge clk); txReady = 1'b1;
    @(posedge clk); #1; txReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {15'b0, irqOut}, 16'h0);
    check("R1 txValid", {15'b0, txValid}, 16'h0);
    check("R1 divisor", divisor, 16'h0001);
    readCheck("R1 lcr", 3'd3, 8'h03);
    readCheck("R1 ier", 3'd1, 8'h00);
    readCheck("R1 lsr", 3'd5, 8'h60);
    readCheck("R1 iir", 3'd2, 8'hC1);

    // R5 framing table
    for (int i = 0; i < NVEC; i++) begin
      busWrite(3'd3, LCR_VEC[i][14:7]);
      @(negedge clk);
      check("R5 fields", {9'b0, wordLen, stopSel, parEn, parEven, parStick, brkCtrl},
            {9'b0, LCR_VEC[i][6:0]});
      readCheck("R5 readback", 3'd3, LCR_VEC[i][14:7]);
    end

    // R4 divisor bank
    busWrite(3'd3, 8'h83);
    busWrite(3'd0, 8'h34);
    busWrite(3'd1, 8'h12);
    @(negedge clk);
    check("R4 divisor", divisor, 16'h1234);
    check("R4 no tx push", {15'b0, txValid}, 16'h0);
    readCheck("R4 dll", 3'd0, 8'h34);
    readCheck("R4 dlm", 3'd1, 8'h12);
    busWrite(3'd3, 8'h03);
    readCheck("R4 ier untouched", 3'd1, 8'h00);
    check("R4 divisor kept", divisor, 16'h1234);

    // R2 / R11 transmit path
    busWrite(3'd0, 8'hA1);
    busWrite(3'd0, 8'hB2);
    @(negedge clk);
    check("R2 valid", {15'b0, txValid}, 16'h1);
    check("R2 oldest", {8'h0, txData}, 16'h00A1);
    readCheck("R11 lsr busy", 3'd5, 8'h00);
    txTake();
    @(negedge clk);
    check("R2 second", {8'h0, txData}, 16'h00B2);
    txTake();
    @(negedge clk);
    check("R2 drained", {15'b0, txValid}, 16'h0);
    txIdle = 1'b0;
    readCheck("R11 shifter busy", 3'd5, 8'h20);
    txIdle = 1'b1;
    readCheck("R11 all idle", 3'd5, 8'h60);

    // R6 transmit depth
    for (int i = 0; i < 17; i++) busWrite(3'd0, 8'h40 + 8'(i));
    cnt = 0;
    @(negedge clk); txReady = 1'b1;
    for (int k = 0; k < 20; k++) begin
      if (k > 0) @(negedge clk);
      if (txValid) begin
        check("R6 order", {8'h0, txData}, {8'h0, 8'h40 + 8'(cnt)});
        cnt++;
      end
    end
    txReady = 1'b0;
    check("R6 accepted", 16'(cnt), 16'd16);

    // R3 receive path
    rxPush(8'h11, 0, 0, 0);
    rxPush(8'h22, 0, 0, 0);
    readCheck("R3 ready", 3'd5, 8'h61);
    readCheck("R3 first", 3'd0, 8'h11);
    readCheck("R3 second", 3'd0, 8'h22);
    readCheck("R3 empty", 3'd5, 8'h60);

    // R7 receive overflow
    for (int i = 0; i < 17; i++) rxPush(8'h60 + 8'(i), 0, 0, 0);
    readCheck("R7 overrun set", 3'd5, 8'h63);
    readCheck("R7 overrun cleared", 3'd5, 8'h61);
    for (int i = 0; i < 16; i++) readCheck("R7 kept order", 3'd0, 8'h60 + 8'(i));
    readCheck("R7 dropped", 3'd5, 8'h60);

    // R8 faults
    rxPush(8'h01, 1, 0, 0);
    readCheck("R8 parity", 3'd5, 8'h65);
    readCheck("R8 parity cleared", 3'd5, 8'h61);
    rxPush(8'h02, 0, 1, 0);
    readCheck("R8 framing", 3'd5, 8'h69);
    readCheck("R8 framing cleared", 3'd5, 8'h61);
    rxPush(8'h03, 0, 0, 1);
    readCheck("R8 break", 3'd5, 8'h71);
    readCheck("R8 break cleared", 3'd5, 8'h61);

    // R9 independent queue clears
    busWrite(3'd0, 8'h55);
    busWrite(3'd0, 8'h66);
    busWrite(3'd2, 8'h04);
    @(negedge clk);
    check("R9 tx cleared", {15'b0, txValid}, 16'h0);
    readCheck("R9 rx kept", 3'd5, 8'h61);
    busWrite(3'd2, 8'h02);
    readCheck("R9 rx cleared", 3'd5, 8'h60);

    // R10 identification priority
    busWrite(3'd1, 8'h07);
    readCheck("R10 tx empty", 3'd2, 8'hC2);
    check("R10 irq", {15'b0, irqOut}, 16'h1);
    rxPush(8'h77, 0, 0, 0);
    readCheck("R10 rx data", 3'd2, 8'hC4);
    readCheck("R10 no side effect", 3'd2, 8'hC4);
    rxPush(8'h78, 0, 1, 0);
    readCheck("R10 line fault", 3'd2, 8'hC6);
    readCheck("R10 lsr read", 3'd5, 8'h69);
    readCheck("R10 back to rx", 3'd2, 8'hC4);
    busWrite(3'd1, 8'h01);
    busWrite(3'd2, 8'h02);
    readCheck("R10 masked tx", 3'd2, 8'hC1);
    check("R10 irq low", {15'b0, irqOut}, 16'h0);
    busWrite(3'd1, 8'h02);
    readCheck("R10 tx only", 3'd2, 8'hC2);
    busWrite(3'd1, 8'h00);
    readCheck("R10 none", 3'd2, 8'hC1);

    // R12 modem registers
    busWrite(3'd4, 8'hFF);
    @(negedge clk);
    check("R12 mcr out", {11'b0, mcrOut}, 16'h001F);
    readCheck("R12 mcr read", 3'd4, 8'h1F);
    msrIn = 8'hA5;
    readCheck("R12 msr", 3'd6, 8'hA5);
    readCheck("R12 spare", 3'd7, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule